// File: doc/BRIEF.md
# Bank GPIO Register File with Masked Writes

This block holds the software-visible state of one GPIO bank: a set of ports, each with a fixed number of pins. Every port has registers for configuration, output enable, output value, pin input, interrupt status, interrupt enable and interrupt type, plus a write-only clear location for status. The block drives the pad output value and pad output enable for every pin. It brings the pad levels in through a two-flop synchronizer. Interrupt detection and any bus bridge live outside this block.

Software has two ways to write a register. A plain write replaces the whole register. A write through the masked alias changes only the pins whose enable bit is set in the upper byte of the data. Several agents can therefore change different pins of one port without a read-modify-write sequence.

The bus is a simple single-cycle interface with no back-pressure. An access is taken on every clock edge where `bus_sel` is high, so there is no ready signal. Read data is combinational in the same cycle as the read request.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every writable register of every port reads 0, and `pad_out` and `pad_oe` are all zero.
- R2: The address fields are: bit 11 selects the masked alias, bits 6:4 select the register kind, and bits 3:2 select the port. Kind codes are 0 configuration, 1 output enable, 2 output value, 3 input, 4 interrupt status, 5 interrupt enable, 6 interrupt type and 7 clear. A plain write stores `bus_wdata[7:0]`. A read returns the register in `bus_rdata[7:0]` with the upper bits zero, in the same cycle.
- R3: On a write with bit 11 set, `bus_wdata[15:8]` are per-pin write enables and `bus_wdata[7:0]` are the new values. A pin whose enable is 0 keeps its value.
- R4: A read through the masked alias returns the same register as the plain address.
- R5: Pin b of port p drives `pad_oe[8p+b]` high only when both its configuration bit and its output-enable bit are 1. `pad_out[8p+b]` equals its output-value bit.
- R6: A read of kind 3 returns the `pad_in` byte of that port as it was two clock edges earlier. Plain and masked writes to kind 3 have no effect.
- R7: A plain write to kind 7 clears each status bit of that port whose data bit is 1. Kind 7 reads as 0, and a masked write to kind 7 has no effect.
- R8: An access with any of address bits 10:7 set touches no register and reads as 0.
- R9: A write to one port leaves the registers of every other port unchanged.
- R10: `pad_out` and `pad_oe` change only on a cycle after a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access request for this cycle |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address inside the bank |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the request cycle |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |

## Verification
The bound checker watches, on every cycle:
- the zero pad state leaving reset;
- pad stability across cycles without a write;
- the kept pins of a masked write to the output register;
- the two-edge latency of input reads;
- zero read data in the unmapped region.

Only the directed scenarios can show:
- plain stores and read-back for every kind;
- write-1-to-clear on status, and that masked clear and input writes are dropped;
- alias reads;
- the configuration and output-enable gating of the pad drivers;
- isolation between ports.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    K_CFG  = 3'd0,
    K_OE   = 3'd1,
    K_OUT  = 3'd2,
    K_IN   = 3'd3,
    K_STA  = 3'd4,
    K_ENB  = 3'd5,
    K_TYPE = 3'd6,
    K_CLR  = 3'd7
  } reg_kind_e;

  localparam int KINDS = 8;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1_q, stage2_q;

  // No reset: the chain refills from the pads within two edges.
  always_ff @(posedge clk) begin
    stage1_q <= d;
    stage2_q <= stage1_q;
  end

  assign q = stage2_q;
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_bank_pkg::*;
#(
  parameter int PINS = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic                          masked,
  input  reg_kind_e                     kind,
  input  logic [2*PINS-1:0]             wbits,
  output logic [KINDS-1:0][PINS-1:0]    regs_o
);
  logic [KINDS-1:0][PINS-1:0] regs_q;
  logic [PINS-1:0] val, en;

  assign val = wbits[PINS-1:0];
  // A plain write behaves as a masked write with every enable set.
  assign en  = masked ? wbits[2*PINS-1:PINS] : {PINS{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      case (kind)
        K_IN: ;
        K_CLR: if (!masked) regs_q[K_STA] <= regs_q[K_STA] & ~val;
        default: regs_q[kind] <= (regs_q[kind] & ~en) | (val & en);
      endcase
    end
  end

  assign regs_o = regs_q;
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int PORTS  = 4,
  parameter int PINS   = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  output logic [DATA_W-1:0]       bus_rdata,
  input  logic [PORTS*PINS-1:0]   pad_in,
  output logic [PORTS*PINS-1:0]   pad_out,
  output logic [PORTS*PINS-1:0]   pad_oe
);
  localparam int NPIN     = PORTS * PINS;
  localparam int PORT_W   = (PORTS > 1) ? $clog2(PORTS) : 1;
  localparam int KIND_LSB = 4;
  localparam int HOLE_LSB = 7;
  localparam int ALIAS_B  = ADDR_W - 1;

  logic                 masked, hit;
  reg_kind_e            kind;
  logic [PORT_W-1:0]    port_idx;
  logic [NPIN-1:0]      in_sync;
  logic [PORTS-1:0][KINDS-1:0][PINS-1:0] regs_all;
  logic [PINS-1:0]      rd_byte;
  logic                 unused_bits;

  assign masked   = bus_addr[ALIAS_B];
  assign kind     = reg_kind_e'(bus_addr[KIND_LSB +: 3]);
  assign port_idx = bus_addr[2 +: PORT_W];
  assign hit      = bus_sel && (bus_addr[ALIAS_B-1:HOLE_LSB] == '0);
  assign unused_bits = ^{bus_wdata[DATA_W-1:2*PINS], bus_addr[1:0]};

  gpio_in_sync #(.W(NPIN)) u_sync (
    .clk (clk),
    .d   (pad_in),
    .q   (in_sync)
  );

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    gpio_port_regs #(.PINS(PINS)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (hit && bus_wr && (port_idx == PORT_W'(p))),
      .masked (masked),
      .kind   (kind),
      .wbits  (bus_wdata[2*PINS-1:0]),
      .regs_o (regs_all[p])
    );
    assign pad_out[p*PINS +: PINS] = regs_all[p][K_OUT];
    assign pad_oe[p*PINS +: PINS]  = regs_all[p][K_CFG] & regs_all[p][K_OE];
  end

  always_comb begin
    rd_byte = '0;
    if (hit && !bus_wr) begin
      if (kind == K_IN) rd_byte = in_sync[port_idx*PINS +: PINS];
      else              rd_byte = regs_all[port_idx][kind];
    end
  end

  assign bus_rdata = DATA_W'(rd_byte);
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int PORTS  = 4,
  parameter int PINS   = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  bus_sel,
  input logic                  bus_wr,
  input logic [ADDR_W-1:0]     bus_addr,
  input logic [DATA_W-1:0]     bus_wdata,
  input logic [DATA_W-1:0]     bus_rdata,
  input logic [PORTS*PINS-1:0] pad_in,
  input logic [PORTS*PINS-1:0] pad_out,
  input logic [PORTS*PINS-1:0] pad_oe
);
  localparam int NPIN   = PORTS * PINS;
  localparam int PORT_W = (PORTS > 1) ? $clog2(PORTS) : 1;

  logic              in_hole, wr_out_masked, rd_in;
  logic [PORT_W-1:0] port;
  logic [NPIN-1:0]   keep_mask;

  assign port          = bus_addr[2 +: PORT_W];
  assign in_hole       = bus_addr[ADDR_W-2:7] != '0;
  assign wr_out_masked = bus_sel && bus_wr && !in_hole && bus_addr[ADDR_W-1]
                         && bus_addr[6:4] == 3'd2;
  assign rd_in         = bus_sel && !bus_wr && !in_hole && bus_addr[6:4] == 3'd3;
  assign keep_mask     = ~(NPIN'(bus_wdata[2*PINS-1:PINS]) << (port*PINS));

  a_r1_reset_pads: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_out == '0 && pad_oe == '0));

  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_wr) |=> ($stable(pad_out) && $stable(pad_oe)));

  a_r3_masked_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_out_masked |=> (((pad_out ^ $past(pad_out)) & $past(keep_mask)) == '0));

  a_r8_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && in_hole) |-> bus_rdata == '0);

  a_r6_input_latency: assert property (@(posedge clk) disable iff (!rst_n)
    rd_in |-> bus_rdata[PINS-1:0] == PINS'($past(pad_in, 2) >> (port*PINS)));
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(
  .PORTS(PORTS), .PINS(PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/tb_gpio_bank_regs.sv
`timescale 1ns/1ps
module tb_gpio_bank_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = 32'h0;
  logic [31:0] pad_out, pad_oe;
  int n_tests = 0, n_fail = 0;

  gpio_bank_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  always #2.5 clk = ~clk;

  function automatic logic [11:0] A(int kind, int port, bit alias_sel);
    return {alias_sel, 4'b0, kind[2:0], port[1:0], 2'b00};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int p = 0; p < 4; p++)
      for (int k = 0; k < 8; k++)
        if (k != 3) begin rd(A(k, p, 0), d); chk("R1 reg zero", d, 0); end
    chk("R1 pad_out", pad_out, 0);
    chk("R1 pad_oe", pad_oe, 0);
  endtask

  task automatic t_plain();
    logic [31:0] d;
    wr(A(0, 1, 0), 32'hFFFF_00A5);
    rd(A(0, 1, 0), d); chk("R2 cfg store, upper bits zero", d, 32'hA5);
    wr(A(5, 2, 0), 32'h0000_003C);
    rd(A(5, 2, 0), d); chk("R2 enable store", d, 32'h3C);
    wr(A(6, 3, 0), 32'h0000_0081);
    rd(A(6, 3, 0), d); chk("R2 type store", d, 32'h81);
    rd(A(0, 0, 0), d); chk("R9 port0 cfg untouched", d, 0);
    rd(A(0, 2, 0), d); chk("R9 port2 cfg untouched", d, 0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    wr(A(2, 0, 0), 32'h0000_00FF);
    wr(A(2, 0, 1), 32'h0000_0F05);
    rd(A(2, 0, 0), d); chk("R3 masked merge", d, 32'hF5);
    chk("R3 pad_out follows", pad_out[7:0], 8'hF5);
    wr(A(2, 0, 1), 32'h0000_00AA);
    rd(A(2, 0, 0), d); chk("R3 no enables no change", d, 32'hF5);
    rd(A(2, 0, 1), d); chk("R4 alias read", d, 32'hF5);
    wr(A(0, 1, 1), 32'h0000_8000);
    rd(A(0, 1, 1), d); chk("R3 clear single pin", d, 32'h25);
  endtask

  task automatic t_pads();
    wr(A(0, 3, 0), 32'h0F);
    wr(A(1, 3, 0), 32'h33);
    wr(A(2, 3, 0), 32'hAA);
    chk("R5 oe gated by cfg", pad_oe[31:24], 8'h03);
    chk("R5 pad_out value", pad_out[31:24], 8'hAA);
    chk("R5 other ports no drive", pad_oe[23:0], 24'h0);
  endtask

  task automatic t_idle();
    logic [31:0] po, pe;
    po = pad_out; pe = pad_oe;
    repeat (4) @(negedge clk);
    chk("R10 pad_out idle", pad_out, po);
    chk("R10 pad_oe idle", pad_oe, pe);
  endtask

  task automatic t_input();
    logic [31:0] d;
    @(negedge clk); pad_in = 32'h1234_5678;
    repeat (3) @(negedge clk);
    rd(A(3, 0, 0), d); chk("R6 input port0", d, 32'h78);
    rd(A(3, 3, 0), d); chk("R6 input port3", d, 32'h12);
    @(negedge clk); pad_in = 32'h1234_56C3;
    rd(A(3, 0, 0), d); chk("R6 one edge still old", d, 32'h78);
    rd(A(3, 0, 0), d); chk("R6 two edges new", d, 32'hC3);
    wr(A(3, 0, 0), 32'h0000_0000);
    wr(A(3, 0, 1), 32'h0000_FF00);
    rd(A(3, 0, 0), d); chk("R6 writes ignored", d, 32'hC3);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    wr(A(4, 1, 0), 32'hFF);
    wr(A(7, 1, 0), 32'h0F);
    rd(A(4, 1, 0), d); chk("R7 w1c", d, 32'hF0);
    rd(A(7, 1, 0), d); chk("R7 clear reads zero", d, 0);
    wr(A(7, 1, 1), 32'hFFFF);
    rd(A(4, 1, 0), d); chk("R7 masked clear ignored", d, 32'hF0);
  endtask

  task automatic t_hole();
    logic [31:0] d;
    wr(12'h0A0, 32'h0000_0000);
    rd(A(2, 0, 0), d); chk("R8 hole write ignored", d, 32'hF5);
    rd(12'h0A0, d); chk("R8 hole read zero", d, 0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_masked();
    t_pads();
    t_idle();
    t_input();
    t_clear();
    t_hole();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule